// File: doc/BRIEF.md
# Alarm threshold programming sequencer

This block loads and applies the per-channel alarm limits of a 16-channel converter. It watches the 16-bit word that the serial front end captures in each chip-select frame, one `frame_valid_i` pulse per word. In normal decoding, a word that carries the entry command selects one of four channel groups. Each frame after that writes one threshold register of that group. The sequence ends early when a word carries the exit flag, and it always ends after eight writes.

All 32 thresholds are held in registers, one high and one low for each channel. Each conversion result comes in with its channel number. It is compared against that channel's limits, and the block produces registered high and low alarm flags. The serial shifter and the converter core lie outside this block.

Top module: `thr_alarm_seq`

## Requirements
- R1: After reset every high threshold is 0xFFF, every low threshold is 0x000, and both alarm flags are 0. No 12-bit result raises an alarm until thresholds are written.
- R2: In normal decoding, a word with bits [15:12] = 1010 starts a sequence for group bits [1:0]. Group g covers channels 4g to 4g+3. Any other word is ignored and writes nothing.
- R3: During a sequence, each frame writes one register of the selected group. Bits [14:12] form the index: bit 12 = 1 selects the high threshold and 0 selects the low one, and bits [14:13] select the channel within the group. Bits [11:0] are the value.
- R4: A data word with bit 15 set is still written. The sequence then ends, so the next frame is decoded as a command.
- R5: After eight data writes the sequence ends even without the exit flag. The next (ninth) data frame is decoded as a command: an entry word starts a new sequence and any other word is ignored.
- R6: A sequence may write fewer than eight registers. Registers it does not address keep their values.
- R7: The high flag is set when the result is strictly greater than the high threshold of its channel. An equal result does not set it.
- R8: The low flag is set when the result is strictly less than the low threshold of its channel. An equal result does not set it.
- R9: Both flags are updated on the clock edge that samples `conv_valid_i` high. They hold while `conv_valid_i` is low, whatever the channel and data inputs do.
- R10: A sequence never changes the thresholds of channels outside its selected group.
- R11: Inside a sequence every word is data, including a word whose upper nibble equals the entry code.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| frame_valid_i | input | 1 | One-cycle pulse when a frame word is captured |
| frame_word_i | input | 16 | Captured frame word |
| conv_valid_i | input | 1 | One-cycle pulse when a conversion result is present |
| conv_chan_i | input | 4 | Channel of the conversion result |
| conv_data_i | input | 12 | Conversion result |
| alarm_hi_o | output | 1 | Result above the high threshold |
| alarm_lo_o | output | 1 | Result below the low threshold |

## Verification
Thresholds are visible only through the alarm flags. A wrong stored value, or a write that lands on the wrong channel or group, therefore shows up only on the first conversion of the affected channel whose result falls between the correct limit and the wrong one. The bench probes every channel at its expected limit and one code beyond it. A sequencer that is in the wrong state leaves the next frame written or dropped when it should not be. That error stays hidden until the probe conversions after the sequence, where the stray or missing value changes a flag one clock after the conversion pulse.

// File: rtl/thr_alarm_pkg.sv
package thr_alarm_pkg;
  typedef enum logic {
    SEQ_IDLE = 1'b0,
    SEQ_LOAD = 1'b1
  } seq_state_e;
endpackage

// File: rtl/thr_seq_fsm.sv
module thr_seq_fsm
  import thr_alarm_pkg::*;
#(
  parameter int unsigned WORD_W     = 16,
  parameter int unsigned DATA_W     = 12,
  parameter int unsigned GRP_W      = 2,
  parameter int unsigned IDX_W      = 3,
  parameter int unsigned CODE_W     = 4,
  parameter logic [CODE_W-1:0] ENTRY_CODE = 4'hA
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              frame_valid_i,
  input  logic [WORD_W-1:0] frame_word_i,
  output logic              wr_en_o,
  output logic [GRP_W-1:0]  wr_grp_o,
  output logic [IDX_W-1:0]  wr_idx_o,
  output logic [DATA_W-1:0] wr_data_o
);
  localparam int unsigned REGS = 1 << IDX_W;
  localparam int unsigned EXIT_BIT = WORD_W - 1;

  seq_state_e        state_q, state_d;
  logic [GRP_W-1:0]  grp_q, grp_d;
  logic [IDX_W-1:0]  cnt_q, cnt_d;

  logic              is_entry;
  logic              exit_flag;
  logic              last_slot;

  assign is_entry  = frame_word_i[WORD_W-1 -: CODE_W] == ENTRY_CODE;
  assign exit_flag = frame_word_i[EXIT_BIT];
  assign last_slot = cnt_q == IDX_W'(REGS - 1);

  always_comb begin
    state_d = state_q;
    grp_d   = grp_q;
    cnt_d   = cnt_q;
    if (frame_valid_i) begin
      unique case (state_q)
        SEQ_IDLE: if (is_entry) begin
          state_d = SEQ_LOAD;
          grp_d   = frame_word_i[GRP_W-1:0];
          cnt_d   = '0;
        end
        SEQ_LOAD: begin
          cnt_d = cnt_q + 1'b1;
          if (exit_flag || last_slot) state_d = SEQ_IDLE;
        end
        default: state_d = SEQ_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= SEQ_IDLE;
      grp_q   <= '0;
      cnt_q   <= '0;
    end else begin
      state_q <= state_d;
      grp_q   <= grp_d;
      cnt_q   <= cnt_d;
    end
  end

  assign wr_en_o   = frame_valid_i && (state_q == SEQ_LOAD);
  assign wr_grp_o  = grp_q;
  assign wr_idx_o  = frame_word_i[EXIT_BIT-1 -: IDX_W];
  assign wr_data_o = frame_word_i[DATA_W-1:0];

  p_entry_starts_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == SEQ_IDLE && frame_valid_i && is_entry)
      |=> (state_q == SEQ_LOAD && cnt_q == '0));

  p_idle_other_stays_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == SEQ_IDLE && !(frame_valid_i && is_entry)) |=> state_q == SEQ_IDLE);

  p_exit_leaves_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_o && exit_flag) |=> state_q == SEQ_IDLE);

  p_eight_max_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_o && last_slot) |=> state_q == SEQ_IDLE);

  p_group_stable_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == SEQ_LOAD) |=> $stable(grp_q));
endmodule

// File: rtl/thr_bank.sv
module thr_bank #(
  parameter int unsigned CHANNELS   = 16,
  parameter int unsigned GROUP_SIZE = 4,
  parameter int unsigned DATA_W     = 12,
  parameter int unsigned GRP_W      = 2,
  parameter int unsigned IDX_W      = 3,
  parameter int unsigned CHAN_W     = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic [GRP_W-1:0]  wr_grp_i,
  input  logic [IDX_W-1:0]  wr_idx_i,
  input  logic [DATA_W-1:0] wr_data_i,
  input  logic [CHAN_W-1:0] rd_chan_i,
  output logic [DATA_W-1:0] rd_hi_o,
  output logic [DATA_W-1:0] rd_lo_o
);
  localparam int unsigned SUB_W = IDX_W - 1;

  logic [DATA_W-1:0] hi_q [CHANNELS];
  logic [DATA_W-1:0] lo_q [CHANNELS];

  for (genvar c = 0; c < CHANNELS; c++) begin : g_chan
    localparam logic [GRP_W-1:0] GRP = GRP_W'(c / GROUP_SIZE);
    localparam logic [SUB_W-1:0] SUB = SUB_W'(c % GROUP_SIZE);
    logic hit;

    assign hit = wr_en_i && (wr_grp_i == GRP) && (wr_idx_i[IDX_W-1:1] == SUB);

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        hi_q[c] <= '1;
        lo_q[c] <= '0;
      end else if (hit) begin
        if (wr_idx_i[0]) hi_q[c] <= wr_data_i;
        else             lo_q[c] <= wr_data_i;
      end
    end

    p_no_write_hold_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !wr_en_i |=> ($stable(hi_q[c]) && $stable(lo_q[c])));

    p_other_group_hold_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (wr_en_i && wr_grp_i != GRP) |=> ($stable(hi_q[c]) && $stable(lo_q[c])));
  end

  assign rd_hi_o = hi_q[rd_chan_i];
  assign rd_lo_o = lo_q[rd_chan_i];
endmodule

// File: rtl/thr_cmp.sv
module thr_cmp #(
  parameter int unsigned DATA_W = 12
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              conv_valid_i,
  input  logic [DATA_W-1:0] conv_data_i,
  input  logic [DATA_W-1:0] hi_thr_i,
  input  logic [DATA_W-1:0] lo_thr_i,
  output logic              alarm_hi_o,
  output logic              alarm_lo_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      alarm_hi_o <= 1'b0;
      alarm_lo_o <= 1'b0;
    end else if (conv_valid_i) begin
      alarm_hi_o <= conv_data_i > hi_thr_i;
      alarm_lo_o <= conv_data_i < lo_thr_i;
    end
  end

  p_flags_hold_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !conv_valid_i |=> ($stable(alarm_hi_o) && $stable(alarm_lo_o)));

  p_max_thr_quiet_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (conv_valid_i && hi_thr_i == '1) |=> !alarm_hi_o);

  p_min_thr_quiet_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (conv_valid_i && lo_thr_i == '0) |=> !alarm_lo_o);
endmodule

// File: rtl/thr_alarm_seq.sv
module thr_alarm_seq #(
  parameter int unsigned CHANNELS   = 16,
  parameter int unsigned GROUP_SIZE = 4,
  parameter int unsigned DATA_W     = 12,
  parameter int unsigned WORD_W     = 16,
  parameter int unsigned CODE_W     = 4,
  parameter logic [CODE_W-1:0] ENTRY_CODE = 4'hA
) (
  input  logic                        clk_i,
  input  logic                        rst_ni,
  input  logic                        frame_valid_i,
  input  logic [WORD_W-1:0]           frame_word_i,
  input  logic                        conv_valid_i,
  input  logic [$clog2(CHANNELS)-1:0] conv_chan_i,
  input  logic [DATA_W-1:0]           conv_data_i,
  output logic                        alarm_hi_o,
  output logic                        alarm_lo_o
);
  localparam int unsigned NUM_GROUPS = CHANNELS / GROUP_SIZE;
  localparam int unsigned GRP_W      = $clog2(NUM_GROUPS);
  localparam int unsigned IDX_W      = $clog2(2 * GROUP_SIZE);
  localparam int unsigned CHAN_W     = $clog2(CHANNELS);

  logic              wr_en;
  logic [GRP_W-1:0]  wr_grp;
  logic [IDX_W-1:0]  wr_idx;
  logic [DATA_W-1:0] wr_data;
  logic [DATA_W-1:0] hi_thr, lo_thr;

  thr_seq_fsm #(
    .WORD_W(WORD_W), .DATA_W(DATA_W), .GRP_W(GRP_W),
    .IDX_W(IDX_W), .CODE_W(CODE_W), .ENTRY_CODE(ENTRY_CODE)
  ) u_fsm (
    .clk_i, .rst_ni, .frame_valid_i, .frame_word_i,
    .wr_en_o(wr_en), .wr_grp_o(wr_grp), .wr_idx_o(wr_idx), .wr_data_o(wr_data)
  );

  thr_bank #(
    .CHANNELS(CHANNELS), .GROUP_SIZE(GROUP_SIZE), .DATA_W(DATA_W),
    .GRP_W(GRP_W), .IDX_W(IDX_W), .CHAN_W(CHAN_W)
  ) u_bank (
    .clk_i, .rst_ni,
    .wr_en_i(wr_en), .wr_grp_i(wr_grp), .wr_idx_i(wr_idx), .wr_data_i(wr_data),
    .rd_chan_i(conv_chan_i), .rd_hi_o(hi_thr), .rd_lo_o(lo_thr)
  );

  thr_cmp #(.DATA_W(DATA_W)) u_cmp (
    .clk_i, .rst_ni, .conv_valid_i, .conv_data_i,
    .hi_thr_i(hi_thr), .lo_thr_i(lo_thr),
    .alarm_hi_o, .alarm_lo_o
  );
endmodule

// File: tb/thr_alarm_seq_tb.sv
module thr_alarm_seq_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        fv = 1'b0;
  logic [15:0] fw = '0;
  logic        cv = 1'b0;
  logic [3:0]  cch = '0;
  logic [11:0] cdat = '0;
  logic        a_hi, a_lo;

  int n_chk = 0;
  int n_bad = 0;
  logic [11:0] exp_hi [16];
  logic [11:0] exp_lo [16];
  int cur_grp = 0;

  always #4 clk = ~clk;

  thr_alarm_seq u_dut (
    .clk_i(clk), .rst_ni(rst_n), .frame_valid_i(fv), .frame_word_i(fw),
    .conv_valid_i(cv), .conv_chan_i(cch), .conv_data_i(cdat),
    .alarm_hi_o(a_hi), .alarm_lo_o(a_lo)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s act=%0h exp=%0h", req, act, exp);
    end
  endtask

  task automatic send_frame(input logic [15:0] w);
    @(negedge clk); fv = 1'b1; fw = w;
    @(negedge clk); fv = 1'b0; fw = '0;
  endtask

  task automatic enter(input int g);
    send_frame({4'hA, 10'h0, 2'(g)});
    cur_grp = g;
  endtask

  task automatic wr(input int k, input bit is_hi, input logic [11:0] v, input bit ex);
    send_frame({ex, 2'(k), is_hi, v});
    if (is_hi) exp_hi[cur_grp*4+k] = v;
    else       exp_lo[cur_grp*4+k] = v;
  endtask

  task automatic convert_chk(input int ch, input logic [11:0] d, input string tag);
    logic eh, el;
    @(negedge clk); cv = 1'b1; cch = 4'(ch); cdat = d;
    @(negedge clk); cv = 1'b0;
    eh = d > exp_hi[ch];
    el = d < exp_lo[ch];
    chk(a_hi == eh, $sformatf("R7 %s ch%0d d=%0h hi", tag, ch, d), a_hi, eh);
    chk(a_lo == el, $sformatf("R8 %s ch%0d d=%0h lo", tag, ch, d), a_lo, el);
  endtask

  task automatic check_chan(input int ch, input string tag);
    convert_chk(ch, exp_hi[ch], tag);
    if (exp_hi[ch] != 12'hFFF) convert_chk(ch, exp_hi[ch] + 12'd1, tag);
    convert_chk(ch, exp_lo[ch], tag);
    if (exp_lo[ch] != 12'h000) convert_chk(ch, exp_lo[ch] - 12'd1, tag);
  endtask

  task automatic check_all(input string tag);
    for (int c = 0; c < 16; c++) check_chan(c, tag);
  endtask

  task automatic t_reset;
    chk(a_hi == 1'b0 && a_lo == 1'b0, "R1 flags after reset", {a_hi, a_lo}, 0);
    for (int c = 0; c < 16; c++) begin
      convert_chk(c, 12'hFFF, "R1");
      convert_chk(c, 12'h000, "R1");
    end
  endtask

  task automatic t_idle_ignore;
    send_frame(16'h5FFF);
    send_frame(16'h0000);
    send_frame(16'hB123);
    send_frame(16'h4123);
    send_frame(16'hFABC);
    check_all("R2 idle words ignored");
  endtask

  task automatic t_full_load;
    enter(1);
    for (int k = 0; k < 4; k++) begin
      wr(k, 1'b1, 12'h800 + 12'(k * 16), 1'b0);
      wr(k, 1'b0, 12'h100 + 12'(k * 16), 1'b0);
    end
    send_frame(16'h2ABC); // ninth data frame, plain word: ignored
    check_all("R3 R5 R10 full group");
  endtask

  task automatic t_partial_exit;
    enter(2);
    wr(0, 1'b1, 12'h700, 1'b0);
    wr(3, 1'b0, 12'h050, 1'b0);
    wr(1, 1'b1, 12'h600, 1'b1);
    send_frame(16'h4555); // after exit: ignored
    for (int c = 8; c < 12; c++) check_chan(c, "R4 exit applied");
    for (int c = 0; c < 8; c++) check_chan(c, "R6 others unchanged");
    for (int c = 12; c < 16; c++) check_chan(c, "R6 others unchanged");
  endtask

  task automatic t_ninth_entry;
    enter(3);
    for (int k = 0; k < 4; k++) begin
      wr(k, 1'b0, 12'h200 + 12'(k), 1'b0);
      wr(k, 1'b1, 12'hE00 + 12'(k), 1'b0);
    end
    enter(0); // ninth frame is a command
    wr(2, 1'b1, 12'h400, 1'b1);
    check_all("R5 ninth frame enters");
  endtask

  task automatic t_entry_as_data;
    enter(0);
    wr(1, 1'b0, 12'h003, 1'b1); // word 0xA003 carries the entry code
    send_frame(16'h7FFF);
    check_all("R11 entry code as data");
  endtask

  task automatic t_boundary;
    enter(1);
    wr(2, 1'b1, 12'h000, 1'b0);
    wr(2, 1'b0, 12'hFFF, 1'b1);
    check_chan(6, "R7 R8 extreme limits");
    convert_chk(6, 12'h800, "R7 R8 both alarms");
  endtask

  task automatic t_hold;
    convert_chk(8, 12'h701, "R9 set hi");
    for (int i = 0; i < 6; i++) begin
      @(negedge clk); cch = 4'(i); cdat = 12'(i * 100);
      chk(a_hi == 1'b1 && a_lo == 1'b0, "R9 hold without conv_valid", {a_hi, a_lo}, 2);
    end
    convert_chk(8, 12'h100, "R9 update");
  endtask

  initial begin
    #(8 * 200000);
    n_bad++;
    $display("FAIL watchdog act=timeout exp=done");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    for (int c = 0; c < 16; c++) begin
      exp_hi[c] = 12'hFFF;
      exp_lo[c] = 12'h000;
    end
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_idle_ignore();
    t_full_load();
    t_partial_exit();
    t_ninth_entry();
    t_entry_as_data();
    t_boundary();
    t_hold();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule